// File: doc/BRIEF.md
# Display Command Decoder

This block sits behind the host interface of a dot-matrix display controller. Each byte it receives carries a select bit. With the select bit high the byte is pixel data: the block forwards it as a one-cycle RAM write request tagged with the current page and column, then advances the address. With the select bit low the byte is a command that updates the control registers. These registers cover the display mode, the addressing direction, power-down, the instruction-page bit, the bias code, the 7-bit operating-voltage code and the page and column address.

A command is identified by its highest set bit, so its operand fills the bits below. The function-set command toggles between two instruction pages. Page 0 holds the display-mode and address commands. Page 1 holds the bias and voltage commands. Every accepted command keeps the block busy for a programmable number of clocks. During that window every byte is dropped and only status reads are served. A status read returns the busy flag and a fixed identification code.

Top module: `lcd_cmd_ctrl`

## Requirements
- R1: After the rst_ni pin is asserted: disp_mode_o=00, pwr_down_o=1, addr_vert_o=0, ext_page_o=0, bias_o=0, vop_o=0, busy_o=0 and wr_req_o=0. The write address is page 0, column 0.
- R2: A byte accepted with byte_is_data_i=1 produces wr_req_o=1 for exactly one cycle, in the following cycle. That cycle carries the byte on wr_data_o and the address in use on wr_page_o/wr_col_o. Data bytes leave every control output unchanged and do not raise busy_o.
- R3: With addr_vert_o=0, each data write increments the column. After column COLS-1 the column returns to 0 and the page increments; after page PAGES-1 the page returns to 0.
- R4: With addr_vert_o=1, each data write increments the page. After page PAGES-1 the page returns to 0 and the column increments; after column COLS-1 the column returns to 0.
- R5: The function-set command 0010_0PVH (highest set bit 5) loads pwr_down_o=P, addr_vert_o=V and ext_page_o=H in either instruction page.
- R6: With ext_page_o=0, the command 0000_1DxE (highest set bit 3) sets disp_mode_o={D,E}. The codes are 00 off, 10 normal, 01 all segments on and 11 inverse.
- R7: With ext_page_o=0, 01xx_yyyy (highest bit 6) sets the page to yyyy and 1xxx_xxxx (highest bit 7) sets the column to the low seven bits. A value at or beyond PAGES or COLS leaves the address unchanged.
- R8: With ext_page_o=1, 0001_xbbb (highest bit 4) loads bias_o=bbb and 1vvv_vvvv (highest bit 7) loads vop_o with the low seven bits, so any of 128 steps can be set.
- R9: A command belonging to the other instruction page has no effect. This covers display mode or page set with ext_page_o=1, and bias with ext_page_o=0.
- R10: Every command accepted while idle holds busy_o high for exactly BUSY_CYCLES cycles, starting the next cycle. Any byte offered while busy_o=1 is dropped.
- R11: stat_rd_i is served even while busy. In the following cycle stat_valid_o=1 and stat_o={busy_o as sampled, 0000, 101}.
- R12: The all-zero command (NOP) changes no control output and no address; it still starts the busy window.
- R13: The command 0000_0001 restores every R1 value and the write address to page 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_valid_i | input | 1 | A byte is offered this cycle |
| byte_is_data_i | input | 1 | 1 = display data, 0 = command |
| byte_i | input | 8 | Offered byte |
| stat_rd_i | input | 1 | Status read request |
| stat_valid_o | output | 1 | Status byte valid |
| stat_o | output | 8 | Status byte: busy, zeros, ID 101 |
| wr_req_o | output | 1 | RAM write request |
| wr_page_o | output | PW | Write page address |
| wr_col_o | output | CW | Write column address |
| wr_data_o | output | 8 | Write data |
| disp_mode_o | output | 2 | Display mode {D,E} |
| pwr_down_o | output | 1 | Power-down |
| addr_vert_o | output | 1 | 1 = vertical addressing |
| ext_page_o | output | 1 | Instruction page select |
| bias_o | output | 3 | Bias code |
| vop_o | output | 7 | Operating voltage code |
| busy_o | output | 1 | Busy flag |

## Verification
A wrong page bit makes the next page-specific command either take effect or vanish, and the very next mode or code output shows it. A corrupted address counter shows up on the next RAM write as a wrong page or column, which the scoreboard compares write by write. A busy counter off by one changes the measured window length, or lets through a byte that should have been dropped, within BUSY_CYCLES+1 cycles. That byte then appears as a stray write or a mode change.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int BIAS_W = 3;
  localparam int VOP_W  = 7;
  localparam logic [2:0] STAT_ID = 3'b101;

  typedef enum logic [3:0] {
    CMD_NOP, CMD_RESET, CMD_FSET, CMD_DISP,
    CMD_SETY, CMD_SETX, CMD_BIAS, CMD_VOP, CMD_NONE
  } cmd_e;

  typedef enum logic [1:0] {
    DISP_OFF = 2'b00, DISP_ALL = 2'b01, DISP_NORM = 2'b10, DISP_INV = 2'b11
  } disp_e;
endpackage

// File: rtl/lcd_cmd_decode.sv
module lcd_cmd_decode
  import lcd_cmd_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ext_i,
  output cmd_e              cmd_o
);
  logic [2:0] lead;
  logic       any;

  // highest set bit picks the opcode; operand sits below it
  always_comb begin
    lead = '0;
    any  = 1'b0;
    for (int i = 0; i < BYTE_W; i++) begin
      if (byte_i[i]) begin
        lead = 3'(i);
        any  = 1'b1;
      end
    end
  end

  always_comb begin
    cmd_o = CMD_NONE;
    if (!any) cmd_o = CMD_NOP;
    else begin
      unique case (lead)
        3'd7: cmd_o = ext_i ? CMD_VOP  : CMD_SETX;
        3'd6: cmd_o = ext_i ? CMD_NONE : CMD_SETY;
        3'd5: cmd_o = CMD_FSET;
        3'd4: cmd_o = ext_i ? CMD_BIAS : CMD_NONE;
        3'd3: cmd_o = ext_i ? CMD_NONE : CMD_DISP;
        3'd0: cmd_o = CMD_RESET;
        default: cmd_o = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/lcd_addr_ctr.sv
module lcd_addr_ctr #(
  parameter int COLS  = 102,
  parameter int PAGES = 9,
  localparam int PW = $clog2(PAGES),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          vert_i,
  input  logic          step_i,
  input  logic          set_page_i,
  input  logic [PW-1:0] page_d_i,
  input  logic          set_col_i,
  input  logic [CW-1:0] col_d_i,
  output logic [PW-1:0] page_o,
  output logic [CW-1:0] col_o
);
  logic page_last, col_last;
  assign page_last = (page_o == PW'(PAGES - 1));
  assign col_last  = (col_o  == CW'(COLS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o <= '0;
      col_o  <= '0;
    end else if (clear_i) begin
      page_o <= '0;
      col_o  <= '0;
    end else begin
      if (set_page_i && (int'(page_d_i) < PAGES)) page_o <= page_d_i;
      if (set_col_i  && (int'(col_d_i)  < COLS))  col_o  <= col_d_i;
      if (step_i) begin
        if (!vert_i) begin
          col_o <= col_last ? '0 : col_o + 1'b1;
          if (col_last) page_o <= page_last ? '0 : page_o + 1'b1;
        end else begin
          page_o <= page_last ? '0 : page_o + 1'b1;
          if (page_last) col_o <= col_last ? '0 : col_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_cmd_ctrl.sv
module lcd_cmd_ctrl
  import lcd_cmd_pkg::*;
#(
  parameter int COLS        = 102,
  parameter int PAGES       = 9,
  parameter int BUSY_CYCLES = 4,
  localparam int PW = $clog2(PAGES),
  localparam int CW = $clog2(COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic              byte_is_data_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              stat_rd_i,
  output logic              stat_valid_o,
  output logic [BYTE_W-1:0] stat_o,
  output logic              wr_req_o,
  output logic [PW-1:0]     wr_page_o,
  output logic [CW-1:0]     wr_col_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [1:0]        disp_mode_o,
  output logic              pwr_down_o,
  output logic              addr_vert_o,
  output logic              ext_page_o,
  output logic [BIAS_W-1:0] bias_o,
  output logic [VOP_W-1:0]  vop_o,
  output logic              busy_o
);
  logic    accept, cmd_acc, dat_acc, soft_rst;
  cmd_e    cmd;
  disp_e   disp_q;
  logic [PW-1:0] page;
  logic [CW-1:0] col;

  assign accept   = byte_valid_i && !busy_o;
  assign cmd_acc  = accept && !byte_is_data_i;
  assign dat_acc  = accept &&  byte_is_data_i;
  assign soft_rst = cmd_acc && (cmd == CMD_RESET);

  lcd_cmd_decode u_dec (
    .byte_i (byte_i),
    .ext_i  (ext_page_o),
    .cmd_o  (cmd)
  );

  lcd_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cmd_acc),
    .busy_o  (busy_o)
  );

  lcd_addr_ctr #(.COLS(COLS), .PAGES(PAGES)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (soft_rst),
    .vert_i     (addr_vert_o),
    .step_i     (dat_acc),
    .set_page_i (cmd_acc && (cmd == CMD_SETY)),
    .page_d_i   (byte_i[PW-1:0]),
    .set_col_i  (cmd_acc && (cmd == CMD_SETX)),
    .col_d_i    (byte_i[CW-1:0]),
    .page_o     (page),
    .col_o      (col)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_q      <= DISP_OFF;
      pwr_down_o  <= 1'b1;
      addr_vert_o <= 1'b0;
      ext_page_o  <= 1'b0;
      bias_o      <= '0;
      vop_o       <= '0;
    end else if (soft_rst) begin
      disp_q      <= DISP_OFF;
      pwr_down_o  <= 1'b1;
      addr_vert_o <= 1'b0;
      ext_page_o  <= 1'b0;
      bias_o      <= '0;
      vop_o       <= '0;
    end else if (cmd_acc) begin
      case (cmd)
        CMD_FSET: begin
          pwr_down_o  <= byte_i[2];
          addr_vert_o <= byte_i[1];
          ext_page_o  <= byte_i[0];
        end
        CMD_DISP: disp_q <= disp_e'({byte_i[2], byte_i[0]});
        CMD_BIAS: bias_o <= byte_i[BIAS_W-1:0];
        CMD_VOP:  vop_o  <= byte_i[VOP_W-1:0];
        default: ;
      endcase
    end
  end

  assign disp_mode_o = disp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_req_o  <= 1'b0;
      wr_page_o <= '0;
      wr_col_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_req_o <= dat_acc;
      if (dat_acc) begin
        wr_page_o <= page;
        wr_col_o  <= col;
        wr_data_o <= byte_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_valid_o <= 1'b0;
      stat_o       <= '0;
    end else begin
      stat_valid_o <= stat_rd_i;
      if (stat_rd_i) stat_o <= {busy_o, 4'b0000, STAT_ID};
    end
  end
endmodule

// File: rtl/lcd_cmd_ctrl_chk.sv
module lcd_cmd_ctrl_chk #(
  parameter int COLS  = 102,
  parameter int PAGES = 9,
  localparam int PW = $clog2(PAGES),
  localparam int CW = $clog2(COLS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          byte_valid_i,
  input logic          byte_is_data_i,
  input logic [7:0]    byte_i,
  input logic          stat_rd_i,
  input logic          stat_valid_o,
  input logic [7:0]    stat_o,
  input logic          wr_req_o,
  input logic [PW-1:0] wr_page_o,
  input logic [CW-1:0] wr_col_o,
  input logic [7:0]    wr_data_o,
  input logic [1:0]    disp_mode_o,
  input logic          pwr_down_o,
  input logic          addr_vert_o,
  input logic          ext_page_o,
  input logic [2:0]    bias_o,
  input logic [6:0]    vop_o,
  input logic          busy_o
);
  a_r2_data_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && byte_is_data_i && !busy_o |=> wr_req_o && wr_data_o == $past(byte_i));

  a_r2_data_keeps_ctl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && byte_is_data_i && !busy_o |=> !busy_o && $stable(disp_mode_o) &&
      $stable(pwr_down_o) && $stable(addr_vert_o) && $stable(ext_page_o) &&
      $stable(bias_o) && $stable(vop_o));

  a_r10_cmd_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && !byte_is_data_i && !busy_o |=> busy_o && !wr_req_o);

  a_r10_drop_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && busy_o |=> !wr_req_o && $stable(disp_mode_o) && $stable(ext_page_o) &&
      $stable(bias_o) && $stable(vop_o) && $stable(pwr_down_o) && $stable(addr_vert_o));

  a_r11_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i |=> stat_valid_o && stat_o[2:0] == 3'b101 && stat_o[6:3] == 4'b0 &&
      stat_o[7] == $past(busy_o));

  a_r7_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> (int'(wr_page_o) < PAGES) && (int'(wr_col_o) < COLS));
endmodule

bind lcd_cmd_ctrl lcd_cmd_ctrl_chk #(.COLS(COLS), .PAGES(PAGES)) u_chk (.*);

// File: tb/lcd_cmd_ctrl_test.sv
module lcd_cmd_ctrl_test;
  localparam int COLS = 102, PAGES = 9, BUSY = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic byte_valid_i = 1'b0, byte_is_data_i = 1'b0, stat_rd_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic stat_valid_o, wr_req_o, pwr_down_o, addr_vert_o, ext_page_o, busy_o;
  logic [7:0] stat_o, wr_data_o;
  logic [3:0] wr_page_o;
  logic [6:0] wr_col_o;
  logic [1:0] disp_mode_o;
  logic [2:0] bias_o;
  logic [6:0] vop_o;

  int n_run = 0, n_fail = 0, wr_seen = 0;
  int m_page = 0, m_col = 0;
  bit m_vert = 0;
  logic [18:0] exp_q[$];
  string       tag_q[$];

  always #5 clk_i = ~clk_i;

  lcd_cmd_ctrl #(.COLS(COLS), .PAGES(PAGES), .BUSY_CYCLES(BUSY)) uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic advance();
    if (!m_vert) begin
      if (m_col == COLS - 1) begin m_col = 0; m_page = (m_page == PAGES - 1) ? 0 : m_page + 1; end
      else m_col++;
    end else begin
      if (m_page == PAGES - 1) begin m_page = 0; m_col = (m_col == COLS - 1) ? 0 : m_col + 1; end
      else m_page++;
    end
  endtask

  task automatic put(input logic [7:0] b, input bit d, input string tag = "R2");
    while (busy_o) @(negedge clk_i);
    byte_valid_i = 1'b1; byte_is_data_i = d; byte_i = b;
    if (d) begin
      exp_q.push_back({4'(m_page), 7'(m_col), b});
      tag_q.push_back(tag);
      advance();
    end
    @(negedge clk_i);
    byte_valid_i = 1'b0;
  endtask

  task automatic raw(input logic [7:0] b, input bit d);
    byte_valid_i = 1'b1; byte_is_data_i = d; byte_i = b;
    @(negedge clk_i);
    byte_valid_i = 1'b0;
  endtask

  task automatic idle();
    while (busy_o) @(negedge clk_i);
  endtask

  task automatic chk_reset_state(input string tag);
    chk(disp_mode_o == 2'b00, {tag, " display off"}, disp_mode_o, 0);
    chk(pwr_down_o == 1'b1, {tag, " power-down"}, pwr_down_o, 1);
    chk(addr_vert_o == 1'b0, {tag, " horizontal"}, addr_vert_o, 0);
    chk(ext_page_o == 1'b0, {tag, " page H"}, ext_page_o, 0);
    chk(bias_o == 3'd0, {tag, " bias"}, bias_o, 0);
    chk(vop_o == 7'd0, {tag, " vop"}, vop_o, 0);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && wr_req_o) begin
      wr_seen++;
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected write", wr_data_o, 0);
      else begin
        logic [18:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({wr_page_o, wr_col_o, wr_data_o} == e, {t, " write addr/data"},
            {wr_page_o, wr_col_o, wr_data_o}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] s_disp, s_bias, s_vop;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_reset_state("R1");
    chk(busy_o == 1'b0 && wr_req_o == 1'b0, "R1 busy/wr idle", {busy_o, wr_req_o}, 0);

    put(8'h20, 0);
    chk(pwr_down_o == 1'b0 && addr_vert_o == 1'b0 && ext_page_o == 1'b0, "R5 fset 000",
        {pwr_down_o, addr_vert_o, ext_page_o}, 0);

    put(8'h09, 0); idle(); chk(disp_mode_o == 2'b01, "R6 all on", disp_mode_o, 1);
    put(8'h0D, 0); idle(); chk(disp_mode_o == 2'b11, "R6 inverse", disp_mode_o, 3);
    put(8'h08, 0); idle(); chk(disp_mode_o == 2'b00, "R6 off", disp_mode_o, 0);
    put(8'h0C, 0); idle(); chk(disp_mode_o == 2'b10, "R6 normal", disp_mode_o, 2);

    put(8'h42, 0); put(8'hE4, 0); m_page = 2; m_col = 100;
    put(8'h11, 1, "R3"); put(8'h22, 1, "R3"); put(8'h33, 1, "R3");
    put(8'hE6, 0); put(8'h49, 0);          // out of range: ignored
    put(8'h44, 1, "R7");
    put(8'h48, 0); put(8'hE5, 0); m_page = 8; m_col = 101;
    put(8'h55, 1, "R3"); put(8'h66, 1, "R3");

    put(8'h22, 0); m_vert = 1;
    chk(addr_vert_o == 1'b1 && pwr_down_o == 1'b0, "R5 fset vertical", addr_vert_o, 1);
    put(8'h47, 0); put(8'h85, 0); m_page = 7; m_col = 5;
    put(8'h77, 1, "R4"); put(8'h88, 1, "R4"); put(8'h99, 1, "R4");

    put(8'h23, 0);
    chk(ext_page_o == 1'b1, "R5 fset H=1", ext_page_o, 1);
    put(8'h15, 0); idle(); chk(bias_o == 3'd5, "R8 bias", bias_o, 5);
    put(8'hFF, 0); idle(); chk(vop_o == 7'h7F, "R8 vop max", vop_o, 'h7F);
    put(8'hC4, 0); idle(); chk(vop_o == 7'h44, "R8 vop mid", vop_o, 'h44);
    put(8'h08, 0); idle(); chk(disp_mode_o == 2'b10, "R9 disp ignored in H=1", disp_mode_o, 2);
    put(8'h40, 0);                          // page set ignored in H=1
    put(8'h22, 0);
    put(8'h13, 0); idle(); chk(bias_o == 3'd5, "R9 bias ignored in H=0", bias_o, 5);
    put(8'hAB, 1, "R9");

    idle();
    s_disp = 8'(disp_mode_o); s_bias = 8'(bias_o); s_vop = 8'(vop_o);
    put(8'h00, 0);
    chk(busy_o == 1'b1, "R12 nop busy", busy_o, 1);
    chk(8'(disp_mode_o) == s_disp && 8'(bias_o) == s_bias && 8'(vop_o) == s_vop &&
        addr_vert_o && !pwr_down_o, "R12 nop unchanged", vop_o, s_vop);
    put(8'hBC, 1, "R12");

    idle();
    put(8'h08, 0);
    n = wr_seen;
    raw(8'h0D, 0); raw(8'hAA, 1);
    stat_rd_i = 1'b1; @(negedge clk_i); stat_rd_i = 1'b0;
    chk(stat_valid_o && stat_o == 8'h85, "R11 status busy", stat_o, 'h85);
    idle();
    chk(disp_mode_o == 2'b00, "R10 dropped cmd", disp_mode_o, 0);
    chk(wr_seen == n, "R10 dropped data", wr_seen, n);
    stat_rd_i = 1'b1; @(negedge clk_i); stat_rd_i = 1'b0;
    chk(stat_valid_o && stat_o == 8'h05, "R11 status idle", stat_o, 'h05);

    put(8'h0C, 0);
    n = 0;
    while (busy_o) begin n++; @(negedge clk_i); end
    chk(n == BUSY, "R10 busy length", n, BUSY);

    put(8'h01, 0);
    chk_reset_state("R13");
    m_page = 0; m_col = 0; m_vert = 0;
    put(8'h5A, 1, "R13");

    put(8'h23, 0); put(8'h9A, 0); put(8'h21, 0); put(8'h43, 0); put(8'h0D, 0);
    idle();
    rst_ni = 1'b0; @(negedge clk_i); rst_ni = 1'b1; @(negedge clk_i);
    chk_reset_state("R1 pin");
    m_page = 0; m_col = 0; m_vert = 0;
    put(8'hC3, 1, "R1");

    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R2 all writes seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule